// File: doc/BRIEF.md
# Multi-mode 12-bit Reload Timer

This block is a 12-bit up-counter with a reload register. It serves four uses, chosen by a mode input: interval timing on a clock-enable tick, counting external events, measuring pulse width, and generating a square wave. When the count passes its all-ones value it restarts from the reload value and raises a sticky overflow request. In square-wave mode it also toggles a dedicated output pin on each overflow.

Software-side access is nibble-wide. The reload value is written in one cycle from three 4-bit words. The live count is read one nibble at a time through a select input. Counting is enabled and disabled by separate one-cycle start and stop commands.

The external pin is asynchronous. It passes through a two-flop synchroniser and then a stability filter. A new level is accepted only after it has held for a set number of sampled cycles. Event mode counts the accepted rising edges. Pulse-width mode counts ticks while the accepted level is high.

Top module: `multimode_reload_timer`

## Requirements
- R1: After reset the count and reload value are 0, the timer is stopped, `sq_o` is 0 and `ovf_irq_o` is 0.
- R2: When `wr_en_i` is high, the reload value becomes {`wr_hi_i`, `wr_mid_i`, `wr_lo_i`} (hi = bits 11:8, lo = bits 3:0) at the next edge. A write leaves the running count unchanged.
- R3: `rd_nib_o` shows nibble `rd_sel_i` of the live count: 0 selects bits 3:0, 1 selects bits 7:4 and 2 selects bits 11:8. Select value 3 reads 0. The path is combinational.
- R4: A `start_i` cycle loads the count from the reload value and sets the running state, without advancing in that cycle. A `stop_i` cycle clears the running state and blocks advance in that same cycle. When both are high, the count is loaded and the timer ends up stopped.
- R5: Mode 0 (interval) advances by one on each running cycle in which `tick_i` is high, and holds otherwise.
- R6: An advance from 0xFFF loads the reload value instead of wrapping, and sets the overflow request.
- R7: The overflow request stays high until `irq_ack_i`. If an acknowledge coincides with a new overflow, the request stays set.
- R8: Mode 1 (event) advances once per accepted rising edge of `ext_pin_i`, whatever `tick_i` is doing.
- R9: A level on `ext_pin_i` is accepted only after it has held for FILT_LEN consecutive sampled cycles (2 by default). A pulse one cycle wide has no effect.
- R10: Mode 2 (pulse width) advances on running `tick_i` cycles only while the accepted pin level is high.
- R11: Mode 3 (square) counts like mode 0, and `sq_o` toggles on every overflow. In any other mode `sq_o` is driven to 0 from the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous-free synchronous reset, active low |
| tick_i | input | 1 | Count enable from the prescaler |
| mode_i | input | 2 | 0 interval, 1 event, 2 pulse width, 3 square |
| start_i | input | 1 | Load count from reload value and run |
| stop_i | input | 1 | Halt counting |
| wr_en_i | input | 1 | Reload write strobe |
| wr_hi_i | input | 4 | Reload bits 11:8 |
| wr_mid_i | input | 4 | Reload bits 7:4 |
| wr_lo_i | input | 4 | Reload bits 3:0 |
| rd_sel_i | input | 2 | Count nibble select |
| rd_nib_o | output | 4 | Selected count nibble |
| ext_pin_i | input | 1 | Asynchronous event / gate pin |
| sq_o | output | 1 | Square-wave output |
| irq_ack_i | input | 1 | Clears the overflow request |
| ovf_irq_o | output | 1 | Sticky overflow request |

## Verification
The bench uses the default parameters: 4-bit nibbles, which give a 12-bit count, and a filter length of 2. With these values a one-cycle glitch and a two-cycle pulse fall on either side of the filter threshold. Reload values of 0xFFD, 0xFFE and 0xFFF bring the wrap point within a few cycles of a start. This makes back-to-back overflows possible, including an acknowledge that lands on an overflow, and it lets the square wave toggle several times in a short run. The read select rotates through all four codes every cycle, so every nibble and the unused code are compared throughout.

// File: rtl/mrt_pkg.sv
package mrt_pkg;
    typedef enum logic [1:0] {
        MODE_INTERVAL = 2'd0,
        MODE_EVENT    = 2'd1,
        MODE_PULSE    = 2'd2,
        MODE_SQUARE   = 2'd3
    } mrt_mode_e;
endpackage

// File: rtl/mrt_pin_cond.sv
// Synchroniser, stability filter and rising-edge pulse for the external pin.
module mrt_pin_cond #(
    parameter int FILT_LEN = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pin_i,
    output logic level_o,
    output logic rise_o
);
    localparam int FC_W = $clog2(FILT_LEN + 1);

    typedef struct packed {
        logic [1:0]      sync;
        logic            level;
        logic            rise;
        logic [FC_W-1:0] run;
    } cond_t;

    cond_t cond_d, cond_q;

    always_comb begin
        cond_d      = cond_q;
        cond_d.sync = {cond_q.sync[0], pin_i};
        cond_d.rise = 1'b0;
        if (cond_q.sync[1] != cond_q.level) begin
            if (cond_q.run == FC_W'(FILT_LEN - 1)) begin
                cond_d.level = cond_q.sync[1];
                cond_d.rise  = cond_q.sync[1];
                cond_d.run   = '0;
            end else begin
                cond_d.run = cond_q.run + 1'b1;
            end
        end else begin
            cond_d.run = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) cond_q <= '0;
        else         cond_q <= cond_d;
    end

    assign level_o = cond_q.level;
    assign rise_o  = cond_q.rise;
endmodule

// File: rtl/mrt_core.sv
// Counter, reload register, run state, overflow request and square wave.
module mrt_core
    import mrt_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  mrt_mode_e        mode_i,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             wr_en_i,
    input  logic [CNT_W-1:0] wr_val_i,
    input  logic             ack_i,
    input  logic             ev_level_i,
    input  logic             ev_rise_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             run_o,
    output logic             flag_o,
    output logic             sq_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] rld;
        logic             run;
        logic             flag;
        logic             sq;
    } core_t;

    core_t core_d, core_q;
    logic  adv_cond, adv, wrap;

    always_comb begin
        unique case (mode_i)
            MODE_EVENT: adv_cond = ev_rise_i;
            MODE_PULSE: adv_cond = tick_i & ev_level_i;
            default:    adv_cond = tick_i;
        endcase
        adv  = core_q.run & ~stop_i & ~start_i & adv_cond;
        wrap = adv & (core_q.cnt == CNT_MAX);
    end

    always_comb begin
        core_d = core_q;
        if (start_i)   core_d.cnt = core_q.rld;
        else if (wrap) core_d.cnt = core_q.rld;
        else if (adv)  core_d.cnt = core_q.cnt + 1'b1;

        if (stop_i)       core_d.run = 1'b0;
        else if (start_i) core_d.run = 1'b1;

        core_d.flag = wrap | (core_q.flag & ~ack_i);
        core_d.sq   = (mode_i == MODE_SQUARE) ? (core_q.sq ^ wrap) : 1'b0;

        if (wr_en_i) core_d.rld = wr_val_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) core_q <= '0;
        else         core_q <= core_d;
    end

    assign cnt_o  = core_q.cnt;
    assign run_o  = core_q.run;
    assign flag_o = core_q.flag;
    assign sq_o   = core_q.sq;
endmodule

// File: rtl/mrt_rd_mux.sv
// Nibble read-back of the live count.
module mrt_rd_mux #(
    parameter int NIB_W = 4,
    parameter int NIBS  = 3,
    localparam int SEL_W = (NIBS > 1) ? $clog2(NIBS) : 1
) (
    input  logic [NIBS*NIB_W-1:0] cnt_i,
    input  logic [SEL_W-1:0]      sel_i,
    output logic [NIB_W-1:0]      nib_o
);
    logic [NIB_W-1:0] nib_arr [NIBS];

    for (genvar g = 0; g < NIBS; g++) begin : g_slice
        assign nib_arr[g] = cnt_i[g*NIB_W +: NIB_W];
    end

    always_comb begin
        nib_o = '0;
        for (int i = 0; i < NIBS; i++) begin
            if (sel_i == SEL_W'(i)) nib_o = nib_arr[i];
        end
    end
endmodule

// File: rtl/multimode_reload_timer.sv
module multimode_reload_timer
    import mrt_pkg::*;
#(
    parameter int NIB_W    = 4,
    parameter int FILT_LEN = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic [1:0]       mode_i,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             wr_en_i,
    input  logic [NIB_W-1:0] wr_hi_i,
    input  logic [NIB_W-1:0] wr_mid_i,
    input  logic [NIB_W-1:0] wr_lo_i,
    input  logic [1:0]       rd_sel_i,
    output logic [NIB_W-1:0] rd_nib_o,
    input  logic             ext_pin_i,
    output logic             sq_o,
    input  logic             irq_ack_i,
    output logic             ovf_irq_o
);
    localparam int NIBS  = 3;
    localparam int CNT_W = NIBS * NIB_W;

    logic             pin_level, pin_rise, run_w;
    logic [CNT_W-1:0] cnt_w;

    mrt_pin_cond #(.FILT_LEN(FILT_LEN)) u_cond (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .pin_i   (ext_pin_i),
        .level_o (pin_level),
        .rise_o  (pin_rise)
    );

    mrt_core #(.CNT_W(CNT_W)) u_core (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .tick_i     (tick_i),
        .mode_i     (mrt_mode_e'(mode_i)),
        .start_i    (start_i),
        .stop_i     (stop_i),
        .wr_en_i    (wr_en_i),
        .wr_val_i   ({wr_hi_i, wr_mid_i, wr_lo_i}),
        .ack_i      (irq_ack_i),
        .ev_level_i (pin_level),
        .ev_rise_i  (pin_rise),
        .cnt_o      (cnt_w),
        .run_o      (run_w),
        .flag_o     (ovf_irq_o),
        .sq_o       (sq_o)
    );

    mrt_rd_mux #(.NIB_W(NIB_W), .NIBS(NIBS)) u_rd (
        .cnt_i (cnt_w),
        .sel_i (rd_sel_i),
        .nib_o (rd_nib_o)
    );
endmodule

// File: rtl/mrt_checker.sv
module mrt_checker #(
    parameter int NIB_W = 4,
    localparam int CNT_W = 3 * NIB_W
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             tick_i,
    input logic [1:0]       mode_i,
    input logic             start_i,
    input logic             stop_i,
    input logic             irq_ack_i,
    input logic [1:0]       rd_sel_i,
    input logic [NIB_W-1:0] rd_nib_o,
    input logic             sq_o,
    input logic             ovf_irq_o,
    input logic [CNT_W-1:0] cnt_i,
    input logic             run_i
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    always_comb begin
        if (rst_ni && rd_sel_i == 2'd2)
            p_rd_top_r3: assert (rd_nib_o == cnt_i[CNT_W-1 -: NIB_W]);
    end

    p_stop_freeze_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stop_i && !start_i |=> $stable(cnt_i) && !run_i);

    p_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_i && mode_i == 2'd0 && tick_i && !start_i && !stop_i && cnt_i != CNT_MAX
        |=> (cnt_i - $past(cnt_i)) == CNT_W'(1));

    p_hold_no_tick_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mode_i == 2'd0 && !tick_i && !start_i |=> $stable(cnt_i));

    p_flag_on_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_i && mode_i == 2'd0 && tick_i && !start_i && !stop_i && cnt_i == CNT_MAX
        |=> ovf_irq_o);

    p_ack_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_ack_i && cnt_i != CNT_MAX |=> !ovf_irq_o);

    p_sq_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mode_i != 2'd3 |=> !sq_o);
endmodule

bind multimode_reload_timer mrt_checker #(.NIB_W(NIB_W)) u_mrt_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .mode_i    (mode_i),
    .start_i   (start_i),
    .stop_i    (stop_i),
    .irq_ack_i (irq_ack_i),
    .rd_sel_i  (rd_sel_i),
    .rd_nib_o  (rd_nib_o),
    .sq_o      (sq_o),
    .ovf_irq_o (ovf_irq_o),
    .cnt_i     (cnt_w),
    .run_i     (run_w)
);

// File: tb/multimode_reload_timer_tb_top.sv
module multimode_reload_timer_tb_top;
    localparam int FILT_LEN = 2;
    localparam int MAXV     = 4095;

    logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b0, start = 1'b0, stop = 1'b0;
    logic       wr_en = 1'b0, pin = 1'b0, ack = 1'b0;
    logic [1:0] mode = 2'd0, rd_sel = 2'd0;
    logic [3:0] wr_hi = 4'd0, wr_mid = 4'd0, wr_lo = 4'd0;
    logic [3:0] rd_nib;
    logic       sq, irq;

    always #4 clk = ~clk;

    multimode_reload_timer dut_i (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .mode_i(mode),
        .start_i(start), .stop_i(stop), .wr_en_i(wr_en),
        .wr_hi_i(wr_hi), .wr_mid_i(wr_mid), .wr_lo_i(wr_lo),
        .rd_sel_i(rd_sel), .rd_nib_o(rd_nib), .ext_pin_i(pin),
        .sq_o(sq), .irq_ack_i(ack), .ovf_irq_o(irq)
    );

    int    checks = 0, fails = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    // behavioural reference state
    int m_cnt, m_rld, m_run, m_flag, m_sq, m_lvl, m_rise, m_fc, m_s1, m_s2;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        int cond, adv, wrap, exp_nib;
        if (!rst_n) begin
            m_cnt = 0; m_rld = 0; m_run = 0; m_flag = 0; m_sq = 0;
            m_lvl = 0; m_rise = 0; m_fc = 0; m_s1 = 0; m_s2 = 0;
        end else begin
            if (mode == 2'd1)      cond = m_rise;
            else if (mode == 2'd2) cond = (tick && m_lvl) ? 1 : 0;
            else                   cond = tick;
            adv  = (m_run != 0 && !stop && !start && cond != 0) ? 1 : 0;
            wrap = (adv != 0 && m_cnt == MAXV) ? 1 : 0;
            if (start)     m_cnt = m_rld;
            else if (wrap) m_cnt = m_rld;
            else if (adv)  m_cnt = m_cnt + 1;
            if (stop)       m_run = 0;
            else if (start) m_run = 1;
            m_flag = (wrap != 0 || (m_flag != 0 && !ack)) ? 1 : 0;
            m_sq   = (mode == 2'd3) ? (m_sq ^ wrap) : 0;
            if (wr_en) m_rld = {20'd0, wr_hi, wr_mid, wr_lo};
            m_rise = 0;
            if (m_s2 != m_lvl) begin
                m_fc++;
                if (m_fc == FILT_LEN) begin
                    m_lvl = m_s2; m_rise = m_s2; m_fc = 0;
                end
            end else m_fc = 0;
            m_s2 = m_s1;
            m_s1 = pin;
        end
        #2;
        if (!done) begin
            exp_nib = (rd_sel == 2'd3) ? 0 : ((m_cnt >> (4 * rd_sel)) & 15);
            chk({cur_req, " count nibble via R3 read path"}, int'(rd_nib), exp_nib);
            chk({cur_req, " sq_o"}, int'(sq), m_sq);
            chk({cur_req, " ovf_irq_o"}, int'(irq), m_flag);
            rd_sel = rd_sel + 2'd1;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_rld(input logic [11:0] v);
        {wr_hi, wr_mid, wr_lo} = v;
        wr_en = 1'b1; cyc(1); wr_en = 1'b0;
    endtask

    task automatic pulse_start();
        start = 1'b1; cyc(1); start = 1'b0;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog all-requirements act=running exp=finished");
            summary();
            $finish;
        end
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cur_req = "R1";
        cyc(1);
        chk("R1 reset sq_o", int'(sq), 0);
        chk("R1 reset ovf_irq_o", int'(irq), 0);
        cyc(3);

        cur_req = "R2";
        write_rld(12'h3A5);
        cyc(3);

        cur_req = "R4";
        pulse_start();
        cyc(3);

        cur_req = "R5";
        tick = 1'b1; cyc(6);
        for (int i = 0; i < 8; i++) begin tick = ~tick; cyc(1); end
        tick = 1'b1;

        cur_req = "R4";
        stop = 1'b1; cyc(1); stop = 1'b0;
        cyc(4);
        start = 1'b1; stop = 1'b1; cyc(1); start = 1'b0; stop = 1'b0;
        cyc(3);
        pulse_start();
        cyc(3);

        cur_req = "R6";
        write_rld(12'hFFD);
        pulse_start();
        cyc(8);

        cur_req = "R7";
        ack = 1'b1; cyc(1); ack = 1'b0;
        cyc(2);
        write_rld(12'hFFF);
        pulse_start();
        cyc(2);
        ack = 1'b1; cyc(3); ack = 1'b0;
        stop = 1'b1; cyc(1); stop = 1'b0;
        ack = 1'b1; cyc(1); ack = 1'b0;
        cyc(2);

        cur_req = "R11";
        mode = 2'd3;
        write_rld(12'hFFE);
        pulse_start();
        cyc(12);
        mode = 2'd0; cyc(3);
        stop = 1'b1; cyc(1); stop = 1'b0;

        cur_req = "R8";
        mode = 2'd1; tick = 1'b0;
        write_rld(12'h000);
        pulse_start();
        for (int i = 0; i < 4; i++) begin
            pin = 1'b1; cyc(3); pin = 1'b0; cyc(3);
        end
        tick = 1'b1;
        for (int i = 0; i < 2; i++) begin
            pin = 1'b1; cyc(4); pin = 1'b0; cyc(4);
        end
        cyc(4);

        cur_req = "R9";
        for (int i = 0; i < 3; i++) begin
            pin = 1'b1; cyc(1); pin = 1'b0; cyc(4);
        end
        pin = 1'b1; cyc(2); pin = 1'b0; cyc(6);

        cur_req = "R10";
        mode = 2'd2; tick = 1'b1;
        pulse_start();
        pin = 1'b1; cyc(10);
        pin = 1'b0; cyc(6);
        pin = 1'b1;
        for (int i = 0; i < 6; i++) begin tick = ~tick; cyc(1); end
        pin = 1'b0; tick = 1'b1;
        cyc(6);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule